// File: doc/BRIEF.md
# Preemptive Bus Arbitration Agent with Fairness Hold-off

This block is the local arbitration agent of one bus master on a shared bus. That bus is arbitrated by a common preempt line, which is active low and wired, a central arbitration-phase signal, and a wired-AND arbitration bus. When the local DMA engine raises a request, the agent pulls the preempt line. It then waits for a fresh arbitration phase and drives its 4-bit priority level onto the arbitration bus. Level 0 is the strongest and level F the weakest. The resolution runs from the most significant bit down: once the agent sees a more significant bit it lost on, it releases its lower bits.

If the resolved bus equals its own level when the phase ends, the agent grants its engine and drops preempt. While it holds the bus, other agents may pull preempt at any time. The agent then gives the bus up at the end of the local burst, or once preempt has been seen active for a bounded number of clocks, whichever comes first. With the fairness option on, the agent does not request again after a tenure until it sees the preempt line idle. With the option off, it joins every arbitration phase. The level and the fairness option are taken from configuration inputs only while the agent is idle.

Top module: `bus_arb_agent`

## Requirements
- R1: After reset, gnt_o is 0, preempt_drive_o is 0 and arb_drive_o is all ones (every bit released).
- R2: When req_i is high in idle and no fairness hold-off is pending, preempt_drive_o goes high one clock later and stays high until the agent wins or req_i drops before arbitration.
- R3: While the agent competes in an arbitration phase, arb_drive_o carries its sampled level, where a 1 bit means released. Outside competition arb_drive_o is all ones.
- R4: When a resolved bus bit is 0 where the agent's own level bit is 1, the agent drives 1 on every less significant bit from the next clock until the phase ends.
- R5: If the resolved bus equals the agent's level in the last phase cycle, then one clock after arb_phase_i falls gnt_o rises and preempt_drive_o falls in the same cycle.
- R6: A losing agent keeps preempt_drive_o high, keeps gnt_o low and competes again in the next phase.
- R7: The agent only joins a phase whose rising edge it sees while it is requesting. A phase already in progress when the request starts is sat out.
- R8: A one-cycle burst_done_i pulse during a grant drops gnt_o on the next clock.
- R9: While granted, once the synchronised preempt line has been active for TENURE_MAX consecutive clocks, gnt_o drops. A grant under constant preempt lasts exactly TENURE_MAX cycles.
- R10: With fairness on, after a tenure the agent does not drive preempt until it has seen the line inactive. With the other agents' preempt released, preempt_drive_o rises SYNC_STAGES+2 clocks later.
- R11: With fairness off and req_i still high, preempt_drive_o rises one clock after gnt_o falls.
- R12: cfg_level_i and cfg_fair_i are sampled only while the agent is idle. A change made during a request has no effect on that request.
- R13: preempt_ni is observed through SYNC_STAGES flip-flops, reset to the inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request from the local DMA engine |
| burst_done_i | input | 1 | One-cycle pulse marking the end of the local burst |
| gnt_o | output | 1 | Local engine owns the bus |
| cfg_level_i | input | 4 | Arbitration level, 0 strongest |
| cfg_fair_i | input | 1 | Fairness hold-off enable |
| preempt_ni | input | 1 | Resolved shared preempt line, active low, asynchronous |
| preempt_drive_o | output | 1 | High pulls the shared preempt line low |
| arb_phase_i | input | 1 | High during an arbitration phase, low during grant |
| arb_bus_i | input | 4 | Resolved wired-AND arbitration bus |
| arb_drive_o | output | 4 | Open-drain level drive, 1 means released |

## Verification
The checks assume that arb_phase_i is synchronous to clk_i and stays high for at least LVL_W+1 clocks, so that the bitwise resolution settles. They also assume that arb_bus_i is the AND of every agent's drive, and that burst_done_i only pulses during a grant. The bench keeps within these limits. Its phases last eight cycles. It builds the bus as the AND of arb_drive_o with one modelled competitor, and that competitor releases all its bits when it would lose. The bench pulses burst_done_i only after it has seen gnt_o high, and it changes configuration during a request only to show that the change is ignored.

// File: rtl/arb_agent_pkg.sv
package arb_agent_pkg;
  localparam int unsigned LVL_W = 4;
  typedef logic [LVL_W-1:0] level_t;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_COMPETE, ST_OWN} agent_state_e;
endpackage

// File: rtl/arb_level_compete.sv
module arb_level_compete #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         active_i,
  input  logic [W-1:0] level_i,
  input  logic [W-1:0] bus_i,
  output logic [W-1:0] drive_o,
  output logic         match_o
);
  logic [W-1:0] stop_q, stop_d, lose_hit;
  logic         match_q;

  // own bit released but bus pulled low: lost at that bit
  assign lose_hit = level_i & ~bus_i;

  for (genvar i = 0; i < W; i++) begin : g_stop
    if (i == W-1) begin : g_top
      assign stop_d[i] = stop_q[i];
    end else begin : g_low
      assign stop_d[i] = stop_q[i] | (|lose_hit[W-1:i+1]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_q  <= '0;
      match_q <= 1'b0;
    end else if (!active_i) begin
      stop_q  <= '0;
      match_q <= 1'b0;
    end else begin
      stop_q  <= stop_d;
      match_q <= (bus_i == level_i);
    end
  end

  assign drive_o = active_i ? (level_i | stop_q) : '1;
  assign match_o = match_q;

  // R4
  stop_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i && $past(active_i) |-> ((stop_q & $past(stop_q)) == $past(stop_q)));
endmodule

// File: rtl/arb_tenure_timer.sv
module arb_tenure_timer #(
  parameter int unsigned TENURE_MAX = 975
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic own_i,
  input  logic preempt_act_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(TENURE_MAX + 1);
  logic [CW-1:0] cnt_q;
  logic          counting;

  assign counting = own_i & preempt_act_i;
  assign expire_o = counting && (cnt_q == CW'(TENURE_MAX - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (!counting || expire_o) cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end

  // R9
  tenure_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !own_i);
  // R9
  tenure_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(TENURE_MAX));
endmodule

// File: rtl/arb_fair_gate.sv
module arb_fair_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fair_en_i,
  input  logic release_i,
  input  logic idle_i,
  input  logic preempt_idle_i,
  output logic block_o
);
  logic block_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        block_q <= 1'b0;
    else if (release_i && fair_en_i)    block_q <= 1'b1;
    else if (idle_i && preempt_idle_i)  block_q <= 1'b0;
  end

  assign block_o = block_q;
endmodule

// File: rtl/bus_arb_agent.sv
module bus_arb_agent
  import arb_agent_pkg::*;
#(
  parameter int unsigned TENURE_MAX  = 975,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             burst_done_i,
  output logic             gnt_o,
  input  logic [LVL_W-1:0] cfg_level_i,
  input  logic             cfg_fair_i,
  input  logic             preempt_ni,
  output logic             preempt_drive_o,
  input  logic             arb_phase_i,
  input  logic [LVL_W-1:0] arb_bus_i,
  output logic [LVL_W-1:0] arb_drive_o
);
  agent_state_e state_q, state_d;
  level_t       lvl_q;
  logic         fair_q, phase_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic         preempt_act, expire, fair_block, won, compete_act, release_w;

  // R13
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[i] <= 1'b1;
      else         sync_q[i] <= (i == 0) ? preempt_ni : sync_q[(i == 0) ? 0 : i-1];
    end
  end
  assign preempt_act = ~sync_q[SYNC_STAGES-1];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (req_i && !fair_block) state_d = ST_REQ;
      ST_REQ:     if (!req_i) state_d = ST_IDLE;
                  else if (arb_phase_i && !phase_q) state_d = ST_COMPETE;
      ST_COMPETE: if (!arb_phase_i) state_d = won ? ST_OWN : ST_REQ;
      ST_OWN:     if (burst_done_i || expire) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lvl_q   <= '1;
      fair_q  <= 1'b0;
      phase_q <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= arb_phase_i;
      if (state_q == ST_IDLE) begin
        lvl_q  <= cfg_level_i;
        fair_q <= cfg_fair_i;
      end
    end
  end

  assign compete_act = (state_q == ST_COMPETE) && arb_phase_i;
  assign release_w   = (state_q == ST_OWN) && (state_d == ST_IDLE);

  arb_level_compete #(.W(LVL_W)) u_compete (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (compete_act),
    .level_i  (lvl_q),
    .bus_i    (arb_bus_i),
    .drive_o  (arb_drive_o),
    .match_o  (won)
  );

  arb_tenure_timer #(.TENURE_MAX(TENURE_MAX)) u_timer (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .own_i         (state_q == ST_OWN),
    .preempt_act_i (preempt_act),
    .expire_o      (expire)
  );

  arb_fair_gate u_fair (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .fair_en_i      (fair_q),
    .release_i      (release_w),
    .idle_i         (state_q == ST_IDLE),
    .preempt_idle_i (!preempt_act),
    .block_o        (fair_block)
  );

  assign gnt_o           = (state_q == ST_OWN);
  assign preempt_drive_o = (state_q == ST_REQ) || (state_q == ST_COMPETE);

  // R5
  gnt_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gnt_o) |-> $past(preempt_drive_o) && !$past(arb_phase_i) && !preempt_drive_o);
  // R3
  drive_only_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_drive_o != '1) |-> preempt_drive_o && arb_phase_i);
  // R10
  fair_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fair_block |-> !preempt_drive_o);
  // R12
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) && ($past(state_q) != ST_IDLE) |-> $stable(lvl_q) && $stable(fair_q));
endmodule

// File: tb/bus_arb_agent_test.sv
module bus_arb_agent_test;
  localparam int unsigned TMAX = 20;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0, burst_done_i = 1'b0, cfg_fair_i = 1'b0, arb_phase_i = 1'b0;
  logic [3:0] cfg_level_i = 4'h3;
  logic gnt_o, preempt_drive_o;
  logic [3:0] arb_drive_o, arb_bus_i, comp_drv;
  logic other_preempt = 1'b0, comp_active = 1'b0;
  logic [3:0] comp_level = 4'h0, exp_lvl = 4'h3, drv_seen;
  int checks = 0, failures = 0, run_len = 0;
  int exp_q[$];
  bit finished = 0;

  always #4 clk = ~clk;

  assign comp_drv  = (comp_active && comp_level < exp_lvl) ? comp_level : 4'hF;
  assign arb_bus_i = arb_drive_o & comp_drv;

  bus_arb_agent #(.TENURE_MAX(TMAX), .SYNC_STAGES(2)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .burst_done_i(burst_done_i),
    .gnt_o(gnt_o), .cfg_level_i(cfg_level_i), .cfg_fair_i(cfg_fair_i),
    .preempt_ni(~(preempt_drive_o | other_preempt)), .preempt_drive_o(preempt_drive_o),
    .arb_phase_i(arb_phase_i), .arb_bus_i(arb_bus_i), .arb_drive_o(arb_drive_o)
  );

  task automatic check(input bit ok, input string rq, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, expv);
    end
  endtask

  task automatic phase(input int len);
    @(negedge clk) arb_phase_i = 1'b1;
    repeat (len) @(negedge clk);
    drv_seen = arb_drive_o;
    arb_phase_i = 1'b0;
  endtask

  // caller sits on a negedge where gnt_o is already high
  task automatic burst(input int n, input bit drop_req);
    exp_q.push_back(n);
    repeat (n-1) @(negedge clk);
    burst_done_i = 1'b1;
    if (drop_req) req_i = 1'b0;
    @(negedge clk) burst_done_i = 1'b0;
  endtask

  // scoreboard monitor: measures each grant tenure
  initial forever begin
    @(negedge clk);
    if (gnt_o) run_len++;
    else if (run_len > 0) begin
      if (exp_q.size() == 0) check(0, "R8/R9 unexpected tenure", run_len, 0);
      else begin
        int e;
        e = exp_q.pop_front();
        check(run_len == e, "R8/R9 tenure length", run_len, e);
      end
      run_len = 0;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(!gnt_o && !preempt_drive_o && arb_drive_o == 4'hF, "R1 reset", {gnt_o, preempt_drive_o, arb_drive_o}, 15);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2 R3 R5 R8: single agent, level 3
    req_i = 1'b1;
    @(negedge clk);
    check(preempt_drive_o, "R2 preempt after request", preempt_drive_o, 1);
    phase(8);
    check(drv_seen == 4'h3, "R3 level driven", drv_seen, 3);
    @(negedge clk);
    check(gnt_o && !preempt_drive_o, "R5 grant and preempt drop", {gnt_o, preempt_drive_o}, 2);
    burst(5, 1);
    @(negedge clk);
    check(!gnt_o && arb_drive_o == 4'hF, "R8 released", {gnt_o, arb_drive_o}, 15);

    // R7: phase already running when request starts
    cfg_level_i = 4'h5; exp_lvl = 4'h5;
    arb_phase_i = 1'b1;
    repeat (2) @(negedge clk);
    req_i = 1'b1;
    repeat (4) @(negedge clk);
    check(preempt_drive_o && arb_drive_o == 4'hF, "R7 sits out running phase", arb_drive_o, 15);
    arb_phase_i = 1'b0;
    repeat (2) @(negedge clk);
    check(!gnt_o, "R7 no grant", gnt_o, 0);

    // R4 R6: lose to level 2
    comp_active = 1'b1; comp_level = 4'h2;
    phase(8);
    check(drv_seen == 4'b0111, "R4 lower bits released", drv_seen, 7);
    @(negedge clk);
    check(!gnt_o && preempt_drive_o, "R6 loser keeps preempt", {gnt_o, preempt_drive_o}, 1);
    comp_active = 1'b0;
    phase(8);
    check(drv_seen == 4'h5, "R6 competes again", drv_seen, 5);
    @(negedge clk);
    check(gnt_o, "R6 wins next phase", gnt_o, 1);
    burst(4, 1);
    @(negedge clk);

    // R9 R11: constant preempt from others, fairness off
    cfg_level_i = 4'h1; exp_lvl = 4'h1; cfg_fair_i = 1'b0;
    other_preempt = 1'b1; req_i = 1'b1;
    repeat (2) @(negedge clk);
    exp_q.push_back(TMAX);
    phase(8);
    @(negedge clk);
    check(gnt_o, "R9 granted", gnt_o, 1);
    while (gnt_o) @(negedge clk);
    check(!preempt_drive_o, "R11 idle cycle after release", preempt_drive_o, 0);
    @(negedge clk);
    check(preempt_drive_o, "R11 re-request without fairness", preempt_drive_o, 1);
    req_i = 1'b0;
    repeat (2) @(negedge clk);

    // R10 R13: fairness on
    cfg_fair_i = 1'b1;
    @(negedge clk) req_i = 1'b1;
    repeat (2) @(negedge clk);
    phase(8);
    @(negedge clk);
    check(gnt_o, "R10 granted", gnt_o, 1);
    burst(3, 0);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check(!preempt_drive_o, "R10 hold-off while preempt active", preempt_drive_o, 0);
    end
    other_preempt = 1'b0;
    repeat (3) @(negedge clk);
    check(!preempt_drive_o, "R13 sync latency", preempt_drive_o, 0);
    @(negedge clk);
    check(preempt_drive_o, "R10 request after idle seen", preempt_drive_o, 1);

    // R12: config change mid-request ignored
    cfg_level_i = 4'h9; cfg_fair_i = 1'b0;
    phase(8);
    check(drv_seen == 4'h1, "R12 level held", drv_seen, 1);
    @(negedge clk);
    check(gnt_o, "R12 granted", gnt_o, 1);
    burst(2, 1);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R8 all tenures seen", exp_q.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule